// File: doc/BRIEF.md
# Edge-Triggered Interrupt Input Counter

This block watches eight asynchronous digital pins and turns selected transitions on them into interrupt requests. Every pin is first brought into the clock domain and reduced to one-cycle rise and fall pulses. Each pin then works on its own in one of two ways. In direct mode, every transition of the chosen polarity latches a request. In counter mode, those transitions step a 16-bit counter up or down against a preset, and a request is latched only when the counter completes a full preset span.

Software uses a small register port to program each pin's mode, polarity, count direction and preset. The same port reads back each counter and the pending request bits, and clears requests by writing ones. Requests stay pending until they are cleared. Each pin has a fixed vector number, `VEC_BASE + index`. The block presents the vector of the lowest-numbered pending pin together with a summary request flag.

Top module: `edge_irq_bank`

## Requirements
- R1: A level change on `pin_in` passes through two synchronizing flops and an edge flop. A qualifying change set up before rising edge k changes the request bit or the count at edge k+2. It does not change them earlier.
- R2: Config bit 1 picks the polarity: 0 means rising transitions qualify and 1 means falling transitions qualify. A transition of the opposite polarity changes neither the request bit nor the count.
- R3: In direct mode (config bit 0 = 0), every qualifying transition sets that pin's request bit and leaves its count unchanged.
- R4: In counter mode counting up (config bit 0 = 1, bit 2 = 0), each qualifying transition adds one to the count. When the count plus one equals the preset, the count returns to 0 instead and the request bit is set.
- R5: In counter mode counting down (config bit 2 = 1), each qualifying transition subtracts one from the count. A transition that finds the count at 1 reloads the preset and sets the request bit.
- R6: A write to region 1 stores a nonzero preset. While the pin is in counter mode, that write also reloads the count (0 going up, the preset going down) and clears the pin's request. A write of zero changes nothing.
- R7: A write to region 0 stores the three config bits. It reloads the count (0 for up, the current preset for down) and does not touch the request bit.
- R8: Reading region 3 returns the pending request bits, which stay set until cleared. Writing region 3 clears every bit written as one. A transition that sets a bit in the same cycle as its clear leaves the bit set.
- R9: Addresses are {region[1:0], index[2:0]}. Region 0 reads {down, fall, mode} in bits 2..0, region 1 reads the preset, and region 2 reads the count. Writes to region 2 are ignored.
- R10: `irq_any` is high while any request is pending. `irq_vec` then equals `VEC_BASE` plus the lowest pending index.
- R11: After reset, all config bits are 0, all counts are 0, all presets are 0xFFFF and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | N_IN | Asynchronous interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | IDX_W+2 | Write address {region, index} |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | IDX_W+2 | Read address {region, index} |
| rd_data | output | CNT_W | Combinational read data |
| irq_req | output | N_IN | Pending request bits |
| irq_any | output | 1 | Any request pending |
| irq_vec | output | VEC_W | Vector of lowest pending pin |

## Verification
A register write takes effect at the rising edge on which it is sampled, so the bench reads back the register on the following low clock phase. A pin change reaches the request bit or count two edges after its first sampling edge. The bench samples one phase before that edge to see the old value and one phase after it to see the new value. For each pin toggle in the random stream, the bench waits four cycles before it checks, so every result has settled. The same-cycle clear case is timed on purpose so that the write strobe lands on exactly the edge where the transition pulse is high.

// File: rtl/eib_pkg.sv
package eib_pkg;
  typedef enum logic [1:0] {
    RG_CFG    = 2'd0,
    RG_PRESET = 2'd1,
    RG_COUNT  = 2'd2,
    RG_REQ    = 2'd3
  } region_e;

  localparam int CFG_MODE = 0;
  localparam int CFG_FALL = 1;
  localparam int CFG_DOWN = 2;
endpackage

// File: rtl/eib_rst_sync.sv
module eib_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_q_n <= stage_q;
    end
  end
endmodule

// File: rtl/eib_sync_edge.sv
module eib_sync_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/eib_chan.sv
module eib_chan import eib_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_d,
  input  logic             pre_we,
  input  logic [CNT_W-1:0] pre_d,
  input  logic             clr,
  output logic             mode_q,
  output logic             fall_q,
  output logic             down_q,
  output logic [CNT_W-1:0] preset_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             req_q,
  output logic             hit
);
  localparam int EXT_W = CNT_W + 1;

  logic             pre_ok, wrap, cnt_en;
  logic [CNT_W-1:0] cnt_d;
  logic             req_d;
  logic [EXT_W-1:0] cnt_inc;

  always_comb begin
    hit     = fall_q ? fall : rise;
    pre_ok  = pre_we && (pre_d != '0);
    cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
    wrap    = 1'b0;
    cnt_en  = 1'b0;
    cnt_d   = cnt_q;
    if (pre_ok && mode_q) begin
      cnt_en = 1'b1;
      cnt_d  = down_q ? pre_d : '0;
    end else if (cfg_we) begin
      cnt_en = 1'b1;
      cnt_d  = cfg_d[CFG_DOWN] ? preset_q : '0;
    end else if (hit && mode_q) begin
      cnt_en = 1'b1;
      if (!down_q) begin
        if (cnt_inc == {1'b0, preset_q}) begin
          cnt_d = '0;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end else begin
        if (cnt_q <= CNT_W'(1)) begin
          cnt_d = preset_q;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
    end
    if (pre_ok && mode_q) begin
      req_d = 1'b0;
    end else begin
      req_d = (req_q & ~clr) | (hit & (mode_q ? wrap : 1'b1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      fall_q   <= 1'b0;
      down_q   <= 1'b0;
      preset_q <= '1;
      cnt_q    <= '0;
      req_q    <= 1'b0;
    end else begin
      if (cfg_we) begin
        mode_q <= cfg_d[CFG_MODE];
        fall_q <= cfg_d[CFG_FALL];
        down_q <= cfg_d[CFG_DOWN];
      end
      if (pre_ok) preset_q <= pre_d;
      if (cnt_en) cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end
endmodule

// File: rtl/edge_irq_bank.sv
module edge_irq_bank import eib_pkg::*; #(
  parameter int N_IN     = 8,
  parameter int CNT_W    = 16,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32,
  parameter int IDX_W    = $clog2(N_IN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_IN-1:0]    pin_in,
  input  logic               wr_en,
  input  logic [IDX_W+1:0]   wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [IDX_W+1:0]   rd_addr,
  output logic [CNT_W-1:0]   rd_data,
  output logic [N_IN-1:0]    irq_req,
  output logic               irq_any,
  output logic [VEC_W-1:0]   irq_vec
);
  logic                    rst_q_n;
  logic [N_IN-1:0]         rise_v, fall_v, hit_v;
  logic [N_IN-1:0]         mode_v, fall_sel_v, down_v;
  logic [N_IN-1:0]         cfg_we_v, pre_we_v, clr_v;
  logic [N_IN*CNT_W-1:0]   cnt_flat, preset_flat;
  region_e                 wr_rg, rd_rg;
  logic [IDX_W-1:0]        wr_idx, rd_idx;

  eib_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  eib_sync_edge #(.W(N_IN)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .din   (pin_in),
    .rise  (rise_v),
    .fall  (fall_v)
  );

  assign wr_rg  = region_e'(wr_addr[IDX_W+1:IDX_W]);
  assign wr_idx = wr_addr[IDX_W-1:0];
  assign rd_rg  = region_e'(rd_addr[IDX_W+1:IDX_W]);
  assign rd_idx = rd_addr[IDX_W-1:0];

  for (genvar g = 0; g < N_IN; g++) begin : g_chan
    assign cfg_we_v[g] = wr_en && (wr_rg == RG_CFG)    && (wr_idx == IDX_W'(g));
    assign pre_we_v[g] = wr_en && (wr_rg == RG_PRESET) && (wr_idx == IDX_W'(g));
    assign clr_v[g]    = wr_en && (wr_rg == RG_REQ)    && wr_data[g];

    eib_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .rise     (rise_v[g]),
      .fall     (fall_v[g]),
      .cfg_we   (cfg_we_v[g]),
      .cfg_d    (wr_data[2:0]),
      .pre_we   (pre_we_v[g]),
      .pre_d    (wr_data),
      .clr      (clr_v[g]),
      .mode_q   (mode_v[g]),
      .fall_q   (fall_sel_v[g]),
      .down_q   (down_v[g]),
      .preset_q (preset_flat[g*CNT_W +: CNT_W]),
      .cnt_q    (cnt_flat[g*CNT_W +: CNT_W]),
      .req_q    (irq_req[g]),
      .hit      (hit_v[g])
    );
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_rg)
      RG_CFG: begin
        rd_data[CFG_MODE] = mode_v[rd_idx];
        rd_data[CFG_FALL] = fall_sel_v[rd_idx];
        rd_data[CFG_DOWN] = down_v[rd_idx];
      end
      RG_PRESET: rd_data = preset_flat[int'(rd_idx)*CNT_W +: CNT_W];
      RG_COUNT:  rd_data = cnt_flat[int'(rd_idx)*CNT_W +: CNT_W];
      RG_REQ:    rd_data[N_IN-1:0] = irq_req;
      default:   rd_data = '0;
    endcase
  end

  always_comb begin
    irq_any = |irq_req;
    irq_vec = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (irq_req[i]) irq_vec = VEC_W'(VEC_BASE + i);
    end
  end
endmodule

// File: rtl/eib_chk.sv
module eib_chk #(
  parameter int N_IN     = 8,
  parameter int CNT_W    = 16,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 32,
  parameter int IDX_W    = 3
) (
  input logic                  clk,
  input logic                  rst_q_n,
  input logic                  wr_en,
  input logic [IDX_W+1:0]      wr_addr,
  input logic [CNT_W-1:0]      wr_data,
  input logic [N_IN-1:0]       irq_req,
  input logic                  irq_any,
  input logic [VEC_W-1:0]      irq_vec,
  input logic [N_IN-1:0]       mode_v,
  input logic [N_IN-1:0]       down_v,
  input logic [N_IN-1:0]       hit_v,
  input logic [N_IN*CNT_W-1:0] cnt_flat,
  input logic [N_IN*CNT_W-1:0] preset_flat
);
  // R10
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_any |-> (irq_vec >= VEC_W'(VEC_BASE)) && (irq_vec < VEC_W'(VEC_BASE + N_IN)));

  for (genvar g = 0; g < N_IN; g++) begin : g_chk
    localparam logic [IDX_W+1:0] A_CFG = {2'd0, IDX_W'(g)};
    localparam logic [IDX_W+1:0] A_PRE = {2'd1, IDX_W'(g)};
    logic clr_hit, pre_hit, cfg_hit;
    assign clr_hit = wr_en && (wr_addr[IDX_W+1:IDX_W] == 2'd3) && wr_data[g];
    assign pre_hit = wr_en && (wr_addr == A_PRE);
    assign cfg_hit = wr_en && (wr_addr == A_CFG);

    // R8
    req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      irq_req[g] && !clr_hit && !pre_hit |=> irq_req[g]);

    // R8
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      !mode_v[g] && hit_v[g] |=> irq_req[g]);

    // R4
    up_bound_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      mode_v[g] && !down_v[g] |->
        cnt_flat[g*CNT_W +: CNT_W] < preset_flat[g*CNT_W +: CNT_W]);

    // R5
    down_bound_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      mode_v[g] && down_v[g] |->
        (cnt_flat[g*CNT_W +: CNT_W] != '0) &&
        (cnt_flat[g*CNT_W +: CNT_W] <= preset_flat[g*CNT_W +: CNT_W]));

    // R6
    zero_preset_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      pre_hit && (wr_data == '0) |=> $stable(preset_flat[g*CNT_W +: CNT_W]));

    // R3
    direct_frozen_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      !mode_v[g] && !cfg_hit |=> $stable(cnt_flat[g*CNT_W +: CNT_W]));
  end
endmodule

bind edge_irq_bank eib_chk #(
  .N_IN(N_IN), .CNT_W(CNT_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/tb_edge_irq_bank.sv
module tb_edge_irq_bank;
  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int CW    = 16;
  localparam int VB    = 32;

  logic          clk, rst_n, wr_en;
  logic [N-1:0]  pin_in;
  logic [4:0]    wr_addr, rd_addr;
  logic [CW-1:0] wr_data, rd_data;
  logic [N-1:0]  irq_req;
  logic          irq_any;
  logic [7:0]    irq_vec;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int m_cnt[N], m_pre[N];
  bit m_mode[N], m_fall[N], m_down[N], m_req[N];

  edge_irq_bank dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_req(irq_req), .irq_any(irq_any), .irq_vec(irq_vec)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [4:0] adr(int rg, int i);
    return {rg[1:0], i[2:0]};
  endfunction

  function automatic logic [N-1:0] exp_req();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = m_req[i];
    return r;
  endfunction

  function automatic logic [7:0] exp_vec();
    for (int i = 0; i < N; i++) if (m_req[i]) return 8'(VB + i);
    return 8'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [CW-1:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  function automatic void model_edge(int i, bit old_l, bit new_l);
    bit q = m_fall[i] ? (old_l && !new_l) : (!old_l && new_l);
    if (!q) return;
    if (!m_mode[i]) m_req[i] = 1;
    else if (!m_down[i]) begin
      if (m_cnt[i] + 1 == m_pre[i]) begin m_cnt[i] = 0; m_req[i] = 1; end
      else m_cnt[i]++;
    end else begin
      if (m_cnt[i] <= 1) begin m_cnt[i] = m_pre[i]; m_req[i] = 1; end
      else m_cnt[i]--;
    end
  endfunction

  function automatic void model_cfg(int i, logic [2:0] d);
    m_mode[i] = d[0]; m_fall[i] = d[1]; m_down[i] = d[2];
    m_cnt[i]  = d[2] ? m_pre[i] : 0;
  endfunction

  function automatic void model_pre(int i, int d);
    if (d == 0) return;
    m_pre[i] = d;
    if (m_mode[i]) begin
      m_cnt[i] = m_down[i] ? d : 0;
      m_req[i] = 0;
    end
  endfunction

  task automatic tgl(int i);
    bit old_l = pin_in[i];
    @(negedge clk) pin_in[i] = ~old_l;
    repeat (4) @(negedge clk);
    model_edge(i, old_l, ~old_l);
  endtask

  task automatic do_cfg(int i, logic [2:0] d);
    wr(adr(0, i), CW'(d));
    model_cfg(i, d);
  endtask

  task automatic do_pre(int i, int d);
    wr(adr(1, i), CW'(d));
    model_pre(i, d);
  endtask

  task automatic do_clr(logic [N-1:0] m);
    wr(adr(3, 0), CW'(m));
    for (int i = 0; i < N; i++) if (m[i]) m_req[i] = 0;
  endtask

  task automatic chk_all(string tag);
    logic [CW-1:0] d;
    for (int i = 0; i < N; i++) begin
      rd(adr(2, i), d);
      chk($sformatf("R4/R5/R9 count ch%0d %s", i, tag), d, m_cnt[i]);
    end
    rd(adr(3, 0), d);
    chk({"R8 req status ", tag}, d, CW'(exp_req()));
    chk({"R8 irq_req ", tag}, irq_req, exp_req());
    chk({"R10 irq_any ", tag}, irq_any, |exp_req());
    chk({"R10 irq_vec ", tag}, irq_vec, exp_vec());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout exp finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] d;
    int seed_unused;
    seed_unused = $urandom(32'h5EED1);
    rst_n = 1'b0; pin_in = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    for (int i = 0; i < N; i++) begin
      m_cnt[i] = 0; m_pre[i] = 'hFFFF; m_mode[i] = 0; m_fall[i] = 0; m_down[i] = 0; m_req[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    rd(adr(1, 5), d); chk("R11 preset reset", d, 16'hFFFF);
    rd(adr(0, 5), d); chk("R11 cfg reset", d, 0);
    chk_all("R11 reset");

    // R1 latency, R3 direct mode on ch0
    @(negedge clk) pin_in[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) chk("R1 before due edge", irq_req[0], 1'b0);
    @(negedge clk) chk("R1 at due edge", irq_req[0], 1'b1);
    model_edge(0, 0, 1);
    chk_all("R3 direct");

    // R2 falling polarity on ch1
    do_cfg(1, 3'b010);
    rd(adr(0, 1), d); chk("R9 cfg readback", d, 16'h2);
    tgl(1); chk("R2 wrong polarity", irq_req[1], 1'b0);
    tgl(1); chk("R2 falling polarity", irq_req[1], 1'b1);

    // R4 counter up on ch2, preset 3
    do_pre(2, 3); do_cfg(2, 3'b001);
    tgl(2); tgl(2); tgl(2); tgl(2);
    chk_all("R4 up partial");
    tgl(2); tgl(2);
    chk("R4 wrap req", irq_req[2], 1'b1);
    chk_all("R4 up wrap");

    // R5 counter down on ch3, preset 2
    do_pre(3, 2); do_cfg(3, 3'b101);
    rd(adr(2, 3), d); chk("R7 down reload", d, 2);
    tgl(3); tgl(3); tgl(3); tgl(3);
    chk("R5 reload req", irq_req[3], 1'b1);
    chk_all("R5 down");

    // R6 zero preset ignored, nonzero preset clears request
    do_pre(3, 0);
    rd(adr(1, 3), d); chk("R6 zero ignored", d, 2);
    chk("R6 zero keeps req", irq_req[3], 1'b1);
    do_pre(3, 7);
    chk("R6 preset clears req", irq_req[3], 1'b0);
    rd(adr(2, 3), d); chk("R6 preset reloads", d, 7);

    // R8 clear in the same cycle as a qualifying edge on ch0
    do_clr(8'hFF);
    chk("R8 clear all", irq_req, 8'h00);
    tgl(0);
    @(negedge clk) pin_in[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) begin wr_en = 1'b1; wr_addr = adr(3, 0); wr_data = 16'h0001; end
    @(negedge clk) wr_en = 1'b0;
    m_req[0] = 1;
    chk("R8 edge beats clear", irq_req[0], 1'b1);
    wr(adr(2, 0), 16'h1234);
    chk_all("R9 count write ignored");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 8;
      int ch = $urandom % N;
      case (op)
        0, 1, 2, 3: tgl(ch);
        4: do_cfg(ch, 3'($urandom));
        5: begin
          int v;
          case ($urandom % 4)
            0: v = 0;
            1: v = 1 + $urandom % 4;
            2: v = $urandom % 65536;
            default: v = 2;
          endcase
          do_pre(ch, v);
        end
        6: do_clr(N'($urandom));
        default: begin
          rd(adr(1, ch), d); chk("R6 preset readback", d, m_pre[ch]);
          rd(adr(0, ch), d);
          chk("R9 cfg readback", d, {13'd0, m_down[ch], m_fall[ch], m_mode[ch]});
        end
      endcase
      chk_all("random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule